// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block carries out one memory or I/O read or write at a time on a bus where sixteen shared lines carry the address first and the data after it. Four further upper lines carry address bits 19..16 while the address is out, then a status nibble. An internal requester presents a 20-bit address, a read/write select, a memory/I/O select, a byte/word size, a segment code and write data. The block runs the bus cycle and returns read data with a one-clock done pulse. It drives an address latch strobe, active-low read and write strobes, an active-low high-byte enable, a transmit/receive direction signal and an I/O indicator. It samples a ready input to stretch the cycle with wait states.

The sequencer has six named states: IDLE, T1 (address out), T2 (turn the lines around and assert the strobe), T3 (data phase, ready sampled), TW (wait state, ready sampled) and T4 (strobes released, done). Transitions: IDLE→T1 when a request is valid; T1→T2; T2→T3; T3→T4 when ready is high, else T3→TW; TW→T4 when ready is high, else TW→TW; T4→IDLE. The requester drops its valid on the done pulse.

Top module: `muxbus_cycle_ctrl`

## Requirements
- R1: In reset and in IDLE: ale low, rd_n and wr_n high, ad_oe low, bhe_n high, dir_tx high, io_sel low, hi_out zero, rsp_done low. An asynchronous reset during a cycle returns all of these at once.
- R2: In T1 (the clock after the request is taken) ale is high for exactly one clock, ad_oe is high, ad_out carries address bits 15..0 (bit 0 forced to 0 for a word access) and hi_out carries address bits 19..16.
- R3: From T2 through T4 hi_out carries the status nibble {2'b00, seg}, with the segment code in bits 1..0: 00 extra, 01 stack, 10 code or none, 11 data.
- R4: bhe_n is low from T1 through T4 for a word access and for a byte access at an odd address; it is high for a byte access at an even address.
- R5: On a read, ad_oe is low from T2 through T4, rd_n is low in T2, T3 and every TW, dir_tx is low from T1 through T4, and rd_n and wr_n are never low together.
- R6: On a write, ad_out carries the steered write data from T2 through T4 with ad_oe high: a word as given; a byte at an odd address has wdata[7:0] on lines 15..8 and zeros on 7..0; a byte at an even address has wdata[7:0] on lines 7..0 and zeros on 15..8. wr_n is low in T2, T3 and every TW.
- R7: ready low at the end of T3 or a TW adds one TW; a cycle with n wait states lasts n+4 clocks from T1 to T4.
- R8: Read data is captured at the end of the last T3 or TW: a word as seen on the lines, a byte at an odd address from lines 15..8, a byte at an even address from lines 7..0, upper result byte zero for bytes. rsp_rdata holds its value until the next read completes, across write cycles.
- R9: rsp_done is high for one clock, in T4, and IDLE follows. A request is taken only in IDLE; request inputs changed or asserted during a cycle do not alter that cycle.
- R10: io_sel is high from T1 through T4 for an I/O access and low for a memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken in IDLE |
| req_addr | input | 20 | Physical address |
| req_write | input | 1 | 1 write, 0 read |
| req_io | input | 1 | 1 I/O space, 0 memory |
| req_word | input | 1 | 1 word, 0 byte |
| req_seg | input | 2 | Segment code for status bits |
| req_wdata | input | 16 | Write data (byte in bits 7..0) |
| rsp_rdata | output | 16 | Read result |
| rsp_done | output | 1 | One-clock completion pulse |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 16 | Shared address/data lines, sensed value |
| hi_out | output | 4 | Upper address / status lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | High-byte enable, active low |
| dir_tx | output | 1 | 1 transmit, 0 receive |
| io_sel | output | 1 | I/O access indicator |
| ready | input | 1 | Slave ready; low inserts wait states |

## Verification
The assertions watch on every cycle the relations that are local in time: the single-clock address strobe, the read and write strobes never overlapping, the lines released whenever the read strobe is low, the wait-state and exit transitions taken on ready, the one-clock done pulse followed by IDLE, the high-byte enable stable across a cycle and the read result held between captures. Only the bench scenarios show the values: the address split across the two line groups, the segment code in the status nibble, the lane steering of write data and read data for each size and alignment, the exact cycle length for zero to three wait states, requests ignored mid-cycle and a reset that cuts a cycle short.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
    localparam int SEG_W = 2;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;
endpackage

// File: rtl/muxbus_phase_fsm.sv
module muxbus_phase_fsm
    import muxbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   ready,
    output phase_e phase,
    output logic   cap
);
    phase_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end

    always_comb begin
        nxt = PH_IDLE;
        unique case (phase)
            PH_IDLE: nxt = start ? PH_T1 : PH_IDLE;
            PH_T1:   nxt = PH_T2;
            PH_T2:   nxt = PH_T3;
            PH_T3:   nxt = ready ? PH_T4 : PH_TW;
            PH_TW:   nxt = ready ? PH_T4 : PH_TW;
            PH_T4:   nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    assign cap = ((phase == PH_T3) || (phase == PH_TW)) && ready;

    // R7: ready low in the data phase inserts a wait state
    p_wait_insert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && !ready) |=> (phase == PH_TW));
    // R7: ready high in the data phase moves to T4
    p_ready_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && ready) |=> (phase == PH_T4));
    // R9: T4 always returns to IDLE
    p_t4_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T4) |=> (phase == PH_IDLE));
endmodule

// File: rtl/muxbus_lane_steer.sv
module muxbus_lane_steer #(
    parameter int DW = 16
) (
    input  logic          word,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] wlanes,
    output logic [DW-1:0] rdata,
    output logic          bhe_n
);
    localparam int LW = DW / 2;

    always_comb begin
        if (word) begin
            wlanes = wdata;
            rdata  = bus_in;
            bhe_n  = 1'b0;
        end else if (a0) begin
            wlanes = {wdata[LW-1:0], {LW{1'b0}}};
            rdata  = {{LW{1'b0}}, bus_in[DW-1:LW]};
            bhe_n  = 1'b0;
        end else begin
            wlanes = {{LW{1'b0}}, wdata[LW-1:0]};
            rdata  = {{LW{1'b0}}, bus_in[LW-1:0]};
            bhe_n  = 1'b1;
        end
    end
endmodule

// File: rtl/muxbus_cycle_ctrl.sv
module muxbus_cycle_ctrl
    import muxbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    input  logic             req_io,
    input  logic             req_word,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [DW-1:0]    req_wdata,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_done,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_in,
    output logic [AW-DW-1:0] hi_out,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             bhe_n,
    output logic             dir_tx,
    output logic             io_sel,
    input  logic             ready
);
    localparam int HI_W = AW - DW;

    phase_e           phase;
    logic             cap;
    logic             accept;
    logic [AW-1:0]    q_addr;
    logic             q_write;
    logic             q_io;
    logic             q_word;
    logic [SEG_W-1:0] q_seg;
    logic [DW-1:0]    q_wdata;
    logic [DW-1:0]    wlanes;
    logic [DW-1:0]    rd_lane;
    logic             lane_bhe_n;
    logic [DW-1:0]    addr_lo;
    logic [HI_W-1:0]  status;

    assign accept  = (phase == PH_IDLE) && req_valid;
    assign addr_lo = q_word ? {q_addr[DW-1:1], 1'b0} : q_addr[DW-1:0];
    assign status  = {{(HI_W-SEG_W){1'b0}}, q_seg};

    muxbus_phase_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (req_valid),
        .ready (ready),
        .phase (phase),
        .cap   (cap)
    );

    muxbus_lane_steer #(.DW(DW)) u_lane (
        .word   (q_word),
        .a0     (q_addr[0]),
        .wdata  (q_wdata),
        .bus_in (ad_in),
        .wlanes (wlanes),
        .rdata  (rd_lane),
        .bhe_n  (lane_bhe_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_write <= 1'b0;
            q_io    <= 1'b0;
            q_word  <= 1'b0;
            q_seg   <= '0;
            q_wdata <= '0;
        end else if (accept) begin
            q_addr  <= req_addr;
            q_write <= req_write;
            q_io    <= req_io;
            q_word  <= req_word;
            q_seg   <= req_seg;
            q_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             rsp_rdata <= '0;
        else if (cap && !q_write) rsp_rdata <= rd_lane;
    end

    always_comb begin
        ale      = 1'b0;
        ad_out   = '0;
        ad_oe    = 1'b0;
        hi_out   = '0;
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        bhe_n    = 1'b1;
        dir_tx   = 1'b1;
        io_sel   = 1'b0;
        rsp_done = 1'b0;
        if (phase != PH_IDLE) begin
            bhe_n  = lane_bhe_n;
            dir_tx = q_write;
            io_sel = q_io;
        end
        unique case (phase)
            PH_IDLE: ;
            PH_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr_lo;
                hi_out = q_addr[AW-1:DW];
            end
            PH_T2, PH_T3, PH_TW: begin
                hi_out = status;
                if (q_write) begin
                    ad_oe  = 1'b1;
                    ad_out = wlanes;
                    wr_n   = 1'b0;
                end else begin
                    rd_n   = 1'b0;
                end
            end
            PH_T4: begin
                hi_out   = status;
                rsp_done = 1'b1;
                if (q_write) begin
                    ad_oe  = 1'b1;
                    ad_out = wlanes;
                end
            end
            default: ;
        endcase
    end

    // R2: address strobe lasts one clock and comes with driven lines
    p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);
    // R5: strobes exclusive, lines released while reading
    p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> wr_n);
    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R9: done is a single-clock pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R4: byte enable stays put across the cycle after T1
    p_bhe_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && phase != PH_IDLE) |-> $stable(bhe_n));
    // R8: read result only moves on a capture
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(rsp_rdata));
endmodule

// File: tb/tb_muxbus_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_muxbus_cycle_ctrl;
    typedef struct packed {
        logic [19:0] addr;
        logic        wr;
        logic        io;
        logic        word;
        logic [1:0]  seg;
        logic [15:0] wdata;
        logic [15:0] bus_rd;
        logic [1:0]  waits;
        logic        ebhe;
        logic [15:0] elanes;
        logic [15:0] erd;
    } vec_t;

    // addr wr io word seg wdata bus_rd waits bhe_n lanes rdata
    localparam vec_t VECS [6] = '{
        '{20'h12344, 1'b0, 1'b0, 1'b1, 2'b11, 16'h0000, 16'hBEEF, 2'd0, 1'b0, 16'h0000, 16'hBEEF},
        '{20'hA0011, 1'b1, 1'b0, 1'b0, 2'b01, 16'h00C3, 16'h0000, 2'd1, 1'b0, 16'hC300, 16'h0000},
        '{20'h00F02, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h5A7E, 2'd2, 1'b1, 16'h0000, 16'h007E},
        '{20'h00060, 1'b1, 1'b1, 1'b1, 2'b10, 16'h1234, 16'h0000, 2'd0, 1'b0, 16'h1234, 16'h0000},
        '{20'hFFFFF, 1'b0, 1'b0, 1'b0, 2'b10, 16'h0000, 16'h9C21, 2'd3, 1'b0, 16'h0000, 16'h009C},
        '{20'h30007, 1'b1, 1'b0, 1'b1, 2'b11, 16'hABCD, 16'h0000, 2'd0, 1'b0, 16'hABCD, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic        req_word = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_done;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in = '0;
    logic [3:0]  hi_out;
    logic        ale, rd_n, wr_n, bhe_n, dir_tx, io_sel;
    logic        ready = 1'b0;

    int checks = 0;
    int errors = 0;

    muxbus_cycle_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_io(req_io), .req_word(req_word),
        .req_seg(req_seg), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .hi_out(hi_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n),
        .dir_tx(dir_tx), .io_sel(io_sel), .ready(ready)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle_checks(input string tag);
        chk({tag, " R1 ale"}, ale, 0);
        chk({tag, " R1 rd_n"}, rd_n, 1);
        chk({tag, " R1 wr_n"}, wr_n, 1);
        chk({tag, " R1 ad_oe"}, ad_oe, 0);
        chk({tag, " R1 bhe_n"}, bhe_n, 1);
        chk({tag, " R1 dir_tx"}, dir_tx, 1);
        chk({tag, " R1 io_sel"}, io_sel, 0);
        chk({tag, " R1 hi_out"}, hi_out, 0);
        chk({tag, " R1 done"}, rsp_done, 0);
    endtask

    task automatic run_vec(input vec_t v);
        logic [15:0] exp_lo;
        exp_lo = v.word ? {v.addr[15:1], 1'b0} : v.addr[15:0];
        @(negedge clk);
        req_addr = v.addr; req_write = v.wr; req_io = v.io; req_word = v.word;
        req_seg = v.seg; req_wdata = v.wdata; req_valid = 1'b1; ready = 1'b0;
        @(negedge clk);                       // T1
        req_valid = 1'b0;
        chk("R2 ale in T1", ale, 1);
        chk("R2 ad_oe in T1", ad_oe, 1);
        chk("R2 address low", ad_out, exp_lo);
        chk("R2 address high", hi_out, v.addr[19:16]);
        chk("R4 bhe_n in T1", bhe_n, v.ebhe);
        chk("R5 dir_tx", dir_tx, v.wr);
        chk("R10 io_sel", io_sel, v.io);
        chk("R5 strobes idle in T1", {rd_n, wr_n}, 2'b11);
        ad_in = v.bus_rd;
        @(negedge clk);                       // T2
        chk("R2 ale low in T2", ale, 0);
        chk("R3 status nibble", hi_out, {2'b00, v.seg});
        if (v.wr) begin
            chk("R6 write lanes T2", ad_out, v.elanes);
            chk("R6 ad_oe T2", ad_oe, 1);
            chk("R6 wr_n T2", {rd_n, wr_n}, 2'b10);
        end else begin
            chk("R5 ad_oe released T2", ad_oe, 0);
            chk("R5 rd_n T2", {rd_n, wr_n}, 2'b01);
        end
        for (int j = 0; j <= int'(v.waits); j++) begin
            @(negedge clk);                   // T3 then TW
            chk("R7 no done in data phase", rsp_done, 0);
            chk("R4 bhe_n held", bhe_n, v.ebhe);
            if (v.wr) chk("R6 wr_n data phase", {rd_n, wr_n}, 2'b10);
            else      chk("R5 rd_n data phase", {rd_n, wr_n}, 2'b01);
            ready = (j == int'(v.waits));
        end
        @(negedge clk);                       // T4
        ready = 1'b0;
        chk("R7 R9 done in T4", rsp_done, 1);
        chk("R9 strobes released T4", {rd_n, wr_n}, 2'b11);
        chk("R3 status in T4", hi_out, {2'b00, v.seg});
        if (v.wr) begin
            chk("R6 write lanes T4", ad_out, v.elanes);
            chk("R6 ad_oe T4", ad_oe, 1);
        end else begin
            chk("R8 read data", rsp_rdata, v.erd);
            chk("R5 ad_oe T4", ad_oe, 0);
        end
        @(negedge clk);                       // IDLE
        chk("R9 done single pulse", rsp_done, 0);
        idle_checks("after cycle");
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_checks("reset");
        chk("R1 rdata reset", rsp_rdata, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 stays idle without request", ale, 0);
        idle_checks("idle");

        foreach (VECS[i]) run_vec(VECS[i]);

        chk("R8 rdata held across write", rsp_rdata, 16'h009C);

        // R9: request inputs ignored mid-cycle
        @(negedge clk);
        req_addr = 20'h51230; req_write = 1'b0; req_io = 1'b0; req_word = 1'b0;
        req_seg = 2'b11; req_valid = 1'b1; ad_in = 16'h4411;
        @(negedge clk);                       // T1
        req_addr = 20'hFFFFF; req_write = 1'b1; req_seg = 2'b00; req_io = 1'b1;
        @(negedge clk);                       // T2
        req_valid = 1'b0;
        chk("R9 seg unchanged mid-cycle", hi_out, 4'h3);
        chk("R9 still a read mid-cycle", {rd_n, wr_n}, 2'b01);
        chk("R9 io_sel unchanged", io_sel, 0);
        @(negedge clk);                       // T3
        ready = 1'b1;
        @(negedge clk);                       // T4
        ready = 1'b0;
        chk("R9 done after ignored change", rsp_done, 1);
        chk("R8 byte even read", rsp_rdata, 16'h0011);
        @(negedge clk);
        chk("R9 no second cycle", ale, 0);
        chk("R9 idle after ignored request", rsp_done, 0);

        // R1: reset cuts a cycle short
        @(negedge clk);
        req_addr = 20'h00100; req_write = 1'b0; req_word = 1'b1; req_seg = 2'b01;
        req_io = 1'b0; req_valid = 1'b1; ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);            // inside TW
        chk("R7 waiting holds rd_n", rd_n, 0);
        rst_n = 1'b0;
        #1;
        idle_checks("mid-cycle reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_checks("after reset release");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule